// File: doc/BRIEF.md
# Masked Vector Compare-Select Unit

This unit executes element-wise operations on two signed source vectors under the control of a per-element predicate mask. Two compare operations build the mask from the sources. A complement operation flips it. Five arithmetic or move operations then produce one destination element per cycle on a single write port, with a per-element write enable. An if/else selection is written as a masked move of one source, a mask complement, then a masked move of the other source.

The `DENSE` parameter picks one of two sequencing schemes. With `DENSE=0` the unit visits every element below the length, one per cycle, and the mask only gates the write enable. With `DENSE=1` the unit searches the mask and visits only the elements whose bit is set, so the run time follows the number of set bits rather than the length.

The operands, the opcode and the length are taken on the cycle `start` is accepted. The mask register is always visible on `maskOut`.

Top module: `vmask_unit`

## Requirements
- R1: Opcode 4 sets mask[i] = (A[i] != 0) and opcode 5 sets mask[i] = (A[i] >= B[i]) with both operands signed, for every i below the effective length; mask bits at or above the length keep their value; the new mask is on `maskOut` in the cycle after the accepted start.
- R2: Opcode 6 inverts every mask bit below the effective length and leaves the higher bits unchanged, so a pass-A run, a complement and a pass-B run together select, per element, the chosen source.
- R3: Opcode 0 writes A+B, opcode 1 writes the low 16 bits of the signed product A*B, opcode 2 writes A arithmetically shifted right by one, opcode 3 writes A and opcode 7 writes B; `wrData` is the result for element `wrIdx`; all arithmetic wraps at 16 bits.
- R4: With DENSE=0, a write operation presents elements 0 up to len-1 in ascending order in the cycles 1 up to len after the accepted start, `busy` is high in those cycles, and `wrEn` equals the mask bit of the element presented.
- R5: With DENSE=1, a write operation presents only the elements whose mask bit is set and whose index is below the length, in ascending order, one per cycle, starting the cycle after the accepted start; `wrEn` is high in each of those cycles, so k set bits take k cycles.
- R6: No element at or above the effective length is ever written; a `lenIn` above 64 is treated as 64, and a length of 0 writes nothing.
- R7: `done` is high for exactly one cycle, the cycle after the last presented element; a mask operation, a zero length, or an all-zero mask under DENSE=1 raises `done` in the cycle after the accepted start.
- R8: `start` is accepted only while the unit is idle (neither `busy` nor `done` high); a start at any other time is ignored, and write operations never change the mask.
- R9: After reset the mask is all zeros and `busy`, `done` and `wrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opIn | input | 3 | Opcode, see R1 to R3 |
| lenIn | input | 7 | Vector length, clamped to 64 |
| srcA | input | 1024 | Source vector A, element i at bits [16i+15:16i] |
| srcB | input | 1024 | Source vector B, same layout |
| wrEn | output | 1 | Write enable for the presented element |
| wrIdx | output | 6 | Index of the presented element |
| wrData | output | 16 | Result for the presented element |
| maskOut | output | 64 | Current mask register |
| busy | output | 1 | An element is being presented this cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
A mask bit that is wrong shows up on `maskOut` in the very next cycle, because the bench compares the full mask against its model after every clock. A scan or index that is wrong shows up as a mismatch on `wrIdx`, `wrEn` or `busy` in the first element cycle that goes astray. In the dense variant it also shifts the `done` pulse away from its expected cycle. A wrong operand latch or ALU case shows up on `wrData` at the first enabled element that uses it.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_MUL   = 3'd1,
    OP_SHR   = 3'd2,
    OP_MOVA  = 3'd3,
    OP_CMPNZ = 3'd4,
    OP_CMPGE = 3'd5,
    OP_MNOT  = 3'd6,
    OP_MOVB  = 3'd7
  } vop_e;

  typedef enum logic [1:0] {
    MK_HOLD = 2'd0,
    MK_NZ   = 2'd1,
    MK_GE   = 2'd2,
    MK_INV  = 2'd3
  } mkop_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  loadOps;
    mkop_e maskOp;
  } strobe_t;

endpackage

// File: rtl/vmask_dp.sv
module vmask_dp
  import vmask_pkg::*;
#(
  parameter int ELEM_W   = 16,
  parameter int NUM_ELEM = 64,
  parameter int IDX_W    = 6,
  parameter int LEN_W    = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [LEN_W-1:0]             effLen,
  input  logic [2:0]                   opIn,
  input  logic [NUM_ELEM*ELEM_W-1:0]   srcA,
  input  logic [NUM_ELEM*ELEM_W-1:0]   srcB,
  input  logic [IDX_W-1:0]             elemIdx,
  output logic [ELEM_W-1:0]            result,
  output logic [NUM_ELEM-1:0]          maskQ
);

  localparam int VEC_W = NUM_ELEM * ELEM_W;

  logic [VEC_W-1:0]    aQ, bQ;
  vop_e                opQ;
  logic [NUM_ELEM-1:0] maskNext;

  // operand capture on accepted start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ  <= '0;
      bQ  <= '0;
      opQ <= OP_ADD;
    end else if (stb.loadOps) begin
      aQ  <= srcA;
      bQ  <= srcB;
      opQ <= vop_e'(opIn);
    end
  end

  // per-lane mask update (R1, R2)
  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_lane
    logic signed [ELEM_W-1:0] laneA, laneB;
    logic                     inLen;
    assign laneA = srcA[g*ELEM_W +: ELEM_W];
    assign laneB = srcB[g*ELEM_W +: ELEM_W];
    assign inLen = effLen > LEN_W'(g);
    assign maskNext[g] = !inLen                 ? maskQ[g] :
                         (stb.maskOp == MK_NZ)  ? (laneA != '0) :
                         (stb.maskOp == MK_GE)  ? (laneA >= laneB) :
                         (stb.maskOp == MK_INV) ? ~maskQ[g] :
                                                  maskQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else       maskQ <= maskNext;
  end

  // element ALU (R3)
  logic signed [ELEM_W-1:0]   elemA, elemB;
  logic signed [2*ELEM_W-1:0] prod;

  always_comb begin
    elemA = aQ[elemIdx*ELEM_W +: ELEM_W];
    elemB = bQ[elemIdx*ELEM_W +: ELEM_W];
    prod  = elemA * elemB;
    case (opQ)
      OP_ADD:  result = elemA + elemB;
      OP_MUL:  result = prod[ELEM_W-1:0];
      OP_SHR:  result = elemA >>> 1;
      OP_MOVB: result = elemB;
      default: result = elemA;
    endcase
  end

endmodule

// File: rtl/vmask_ctrl.sv
module vmask_ctrl
  import vmask_pkg::*;
#(
  parameter int NUM_ELEM = 64,
  parameter bit DENSE    = 1'b0,
  parameter int IDX_W    = 6,
  parameter int LEN_W    = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2:0]          opIn,
  input  logic [LEN_W-1:0]    lenIn,
  input  logic [NUM_ELEM-1:0] maskQ,
  output strobe_t             stb,
  output logic [LEN_W-1:0]    effLen,
  output logic [IDX_W-1:0]    elemIdx,
  output logic                wrEn,
  output logic                busy,
  output logic                done
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(NUM_ELEM);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;

  state_e           state, stateNext;
  logic [IDX_W-1:0] idxNext;
  logic [LEN_W-1:0] lenQ;
  vop_e             opCode;
  logic             accept, isWrite;
  logic [LEN_W-1:0] scanFrom, scanLim;
  logic             hit;
  logic [IDX_W-1:0] hitIdx;

  assign opCode = vop_e'(opIn);
  assign effLen = (lenIn > FULL_LEN) ? FULL_LEN : lenIn;       // R6 clamp
  assign accept = start && (state == ST_IDLE);                 // R8
  assign isWrite = !(opCode inside {OP_CMPNZ, OP_CMPGE, OP_MNOT});

  always_comb begin
    stb.loadOps = accept;
    stb.maskOp  = MK_HOLD;
    if (accept) begin
      case (opCode)
        OP_CMPNZ: stb.maskOp = MK_NZ;
        OP_CMPGE: stb.maskOp = MK_GE;
        OP_MNOT:  stb.maskOp = MK_INV;
        default:  stb.maskOp = MK_HOLD;
      endcase
    end
  end

  assign scanFrom = accept ? '0 : (LEN_W'(elemIdx) + LEN_W'(1));
  assign scanLim  = accept ? effLen : lenQ;

  // mask search, lowest set index in [scanFrom, scanLim) (R5)
  if (DENSE) begin : g_scan
    always_comb begin
      hit    = 1'b0;
      hitIdx = '0;
      for (int i = NUM_ELEM - 1; i >= 0; i--) begin
        if (maskQ[i] && (LEN_W'(i) >= scanFrom) && (LEN_W'(i) < scanLim)) begin
          hit    = 1'b1;
          hitIdx = IDX_W'(i);
        end
      end
    end
  end else begin : g_noscan
    assign hit    = 1'b0;
    assign hitIdx = '0;
  end

  always_comb begin
    stateNext = state;
    idxNext   = elemIdx;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (!isWrite || effLen == '0) begin
            stateNext = ST_FIN;
          end else if (DENSE) begin
            stateNext = hit ? ST_RUN : ST_FIN;
            idxNext   = hitIdx;
          end else begin
            stateNext = ST_RUN;
            idxNext   = '0;
          end
        end
      end
      ST_RUN: begin
        if (DENSE) begin
          if (hit) idxNext = hitIdx;
          else     stateNext = ST_FIN;
        end else if (LEN_W'(elemIdx) == lenQ - LEN_W'(1)) begin
          stateNext = ST_FIN;
        end else begin
          idxNext = elemIdx + IDX_W'(1);
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      elemIdx <= '0;
      lenQ    <= '0;
    end else begin
      state   <= stateNext;
      elemIdx <= idxNext;
      if (accept) lenQ <= effLen;
    end
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_FIN);
  assign wrEn = busy && (DENSE || maskQ[elemIdx]);            // R4, R5

endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
  import vmask_pkg::*;
#(
  parameter int ELEM_W   = 16,
  parameter int NUM_ELEM = 64,
  parameter bit DENSE    = 1'b0
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic                                       start,
  input  logic [2:0]                                 opIn,
  input  logic [$clog2(NUM_ELEM+1)-1:0]              lenIn,
  input  logic [NUM_ELEM*ELEM_W-1:0]                 srcA,
  input  logic [NUM_ELEM*ELEM_W-1:0]                 srcB,
  output logic                                       wrEn,
  output logic [$clog2(NUM_ELEM)-1:0]                wrIdx,
  output logic [ELEM_W-1:0]                          wrData,
  output logic [NUM_ELEM-1:0]                        maskOut,
  output logic                                       busy,
  output logic                                       done
);

  localparam int IDX_W = $clog2(NUM_ELEM);
  localparam int LEN_W = $clog2(NUM_ELEM + 1);

  strobe_t          stb;
  logic [LEN_W-1:0] effLen;

  vmask_ctrl #(
    .NUM_ELEM(NUM_ELEM), .DENSE(DENSE), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opIn(opIn), .lenIn(lenIn),
    .maskQ(maskOut), .stb(stb), .effLen(effLen), .elemIdx(wrIdx),
    .wrEn(wrEn), .busy(busy), .done(done)
  );

  vmask_dp #(
    .ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .effLen(effLen), .opIn(opIn),
    .srcA(srcA), .srcB(srcB), .elemIdx(wrIdx), .result(wrData),
    .maskQ(maskOut)
  );

endmodule

// File: rtl/vmask_unit_chk.sv
module vmask_unit_chk #(
  parameter int ELEM_W   = 16,
  parameter int NUM_ELEM = 64,
  parameter bit DENSE    = 1'b0
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              start,
  input logic [$clog2(NUM_ELEM+1)-1:0]     lenIn,
  input logic                              wrEn,
  input logic [$clog2(NUM_ELEM)-1:0]       wrIdx,
  input logic [NUM_ELEM-1:0]               maskOut,
  input logic                              busy,
  input logic                              done
);

  localparam int IDX_W = $clog2(NUM_ELEM);
  localparam int LEN_W = $clog2(NUM_ELEM + 1);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(NUM_ELEM);

  logic [LEN_W-1:0] lenSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lenSeen <= '0;
    else if (start && !busy && !done)
      lenSeen <= (lenIn > FULL_LEN) ? FULL_LEN : lenIn;
  end

  p_wr_below_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (LEN_W'(wrIdx) < lenSeen));

  p_wr_only_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);

  p_dense_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    (DENSE && busy) |-> (wrEn && maskOut[wrIdx]));

  p_simple_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!DENSE && busy && $past(busy)) |-> (wrIdx == IDX_W'($past(wrIdx) + 1'b1)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_run_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(maskOut));

endmodule

bind vmask_unit vmask_unit_chk #(
  .ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM), .DENSE(DENSE)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .lenIn(lenIn), .wrEn(wrEn),
  .wrIdx(wrIdx), .maskOut(maskOut), .busy(busy), .done(done)
);

// File: tb/vmask_unit_tb.sv
`timescale 1ns/1ps
module vmask_unit_tb;

  localparam int W = 16;
  localparam int N = 64;

  typedef struct packed {
    logic [6:0]  idx;
    logic [15:0] data;
    logic        en;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] opIn = '0;
  logic [6:0] lenIn = '0;
  logic [N*W-1:0] srcA = '0, srcB = '0;

  logic enS, busyS, doneS, enD, busyD, doneD;
  logic [5:0] idxS, idxD;
  logic [15:0] dataS, dataD;
  logic [N-1:0] maskS, maskD;

  int checks = 0;
  int errors = 0;
  logic signed [15:0] aV [N];
  logic signed [15:0] bV [N];
  logic [N-1:0] mdlMask = '0;
  exp_t qS[$];
  exp_t qD[$];

  always #10 clk = ~clk;

  vmask_unit #(.ELEM_W(W), .NUM_ELEM(N), .DENSE(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opIn(opIn), .lenIn(lenIn),
    .srcA(srcA), .srcB(srcB), .wrEn(enS), .wrIdx(idxS), .wrData(dataS),
    .maskOut(maskS), .busy(busyS), .done(doneS));

  vmask_unit #(.ELEM_W(W), .NUM_ELEM(N), .DENSE(1'b1)) u_dutDense (
    .clk(clk), .rstN(rstN), .start(start), .opIn(opIn), .lenIn(lenIn),
    .srcA(srcA), .srcB(srcB), .wrEn(enD), .wrIdx(idxD), .wrData(dataD),
    .maskOut(maskD), .busy(busyD), .done(doneD));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] refRes(input int op,
      input logic signed [15:0] a, input logic signed [15:0] b);
    logic signed [31:0] p;
    p = 32'(a) * 32'(b);
    case (op)
      0: return a + b;
      1: return p[15:0];
      2: return 16'(a >>> 1);
      7: return b;
      default: return a;
    endcase
  endfunction

  task automatic setVec(input int kind);
    for (int i = 0; i < N; i++) begin
      case (kind)
        1: aV[i] = '0;
        2: aV[i] = 16'(i * 91 + 3);
        default: aV[i] = (i % 5 == 0) ? 16'sd0 : 16'(i * 37 - 900);
      endcase
      bV[i] = 16'(500 - i * 23);
      srcA[i*W +: W] = aV[i];
      srcB[i*W +: W] = bV[i];
    end
  endtask

  task automatic cmpCycle(input string name, input int cyc, input exp_t q[$],
                          input bit dense, input logic en, input logic [5:0] idx,
                          input logic [15:0] data, input logic bsy, input logic dn);
    string tg;
    tg = dense ? "R5" : "R4";
    if (cyc < q.size()) begin
      chk(bsy == 1'b1, tg, {name, " busy"}, 64'(bsy), 64'd1);
      chk(7'(idx) == q[cyc].idx, tg, {name, " wrIdx"}, 64'(idx), 64'(q[cyc].idx));
      chk(en == q[cyc].en, tg, {name, " wrEn"}, 64'(en), 64'(q[cyc].en));
      if (q[cyc].en)
        chk(data == q[cyc].data, "R3", {name, " wrData"}, 64'(data), 64'(q[cyc].data));
    end else begin
      chk(dn == (cyc == q.size()), "R7", {name, " done"}, 64'(dn), 64'(cyc == q.size()));
      chk(en == 1'b0, "R6", {name, " wrEn past end"}, 64'(en), 64'd0);
    end
  endtask

  task automatic doOp(input int op, input int len, input bit poke);
    int effLen;
    int n;
    exp_t e;
    string mtag;
    effLen = (len > N) ? N : len;
    qS.delete();
    qD.delete();
    mtag = "R8";
    if (op == 4 || op == 5 || op == 6) begin
      mtag = (op == 6) ? "R2" : "R1";
      for (int i = 0; i < effLen; i++) begin
        if (op == 4)      mdlMask[i] = (aV[i] != 0);
        else if (op == 5) mdlMask[i] = (aV[i] >= bV[i]);
        else              mdlMask[i] = ~mdlMask[i];
      end
    end else begin
      for (int i = 0; i < effLen; i++) begin
        e.idx  = 7'(i);
        e.data = refRes(op, aV[i], bV[i]);
        e.en   = mdlMask[i];
        qS.push_back(e);
        if (mdlMask[i]) qD.push_back(e);
      end
    end
    opIn  = 3'(op);
    lenIn = 7'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = ((qS.size() > qD.size()) ? qS.size() : qD.size()) + 2;
    for (int c = 0; c < n; c++) begin
      cmpCycle("simple", c, qS, 1'b0, enS, idxS, dataS, busyS, doneS);
      cmpCycle("dense", c, qD, 1'b1, enD, idxD, dataD, busyD, doneD);
      chk(maskS == mdlMask, mtag, "simple mask", maskS, mdlMask);
      chk(maskD == mdlMask, mtag, "dense mask", maskD, mdlMask);
      if (poke && c == 1) begin
        start = 1'b1;    // R8: busy, must be ignored
        opIn  = 3'd4;
        lenIn = 7'd64;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    setVec(0);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(maskS == '0 && maskD == '0, "R9", "reset mask", maskS | maskD, 64'd0);
    chk(!busyS && !busyD, "R9", "reset busy", 64'(busyS | busyD), 64'd0);
    chk(!doneS && !doneD, "R9", "reset done", 64'(doneS | doneD), 64'd0);
    chk(!enS && !enD, "R9", "reset wrEn", 64'(enS | enD), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    doOp(4, 64, 1'b0);   // R1 nonzero test
    doOp(0, 64, 1'b0);   // R3 add
    doOp(1, 20, 1'b0);   // R3 mul, short length
    doOp(2, 33, 1'b0);   // R3 shift
    doOp(5, 64, 1'b0);   // R1 signed compare
    doOp(3, 64, 1'b0);   // pass A under mask
    doOp(6, 64, 1'b0);   // R2 complement
    doOp(7, 64, 1'b0);   // pass B under inverted mask
    doOp(5, 10, 1'b0);   // R1 upper bits held
    doOp(6, 37, 1'b0);   // R2 partial complement
    doOp(3, 0, 1'b0);    // R6 zero length
    setVec(1);
    doOp(4, 64, 1'b0);   // all-zero mask
    doOp(0, 64, 1'b0);   // R7 dense done right away
    setVec(2);
    doOp(4, 100, 1'b0);  // R6 clamp, mask all ones
    doOp(1, 100, 1'b0);  // R6 clamp on write
    setVec(0);
    doOp(0, 10, 1'b1);   // R8 start during run ignored

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule